// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block converts one parallel data word at a time into an asynchronous serial frame on a single output line. A six-bit line-control input sets the frame shape: a data length of five to eight bits, optional parity (odd, even or a fixed value), and one, one-and-a-half or two stop bits. Words are handed over through a valid/ready handshake. Bit timing comes from an external enable strobe that pulses at sixteen times the bit rate, so the block contains no rate divider.

The line rests high. A frame is a low start bit, the data bits with the least significant first, the optional parity bit, and the stop bits at logic 1. When another word is offered before the current frame ends, its start bit follows the last stop bit directly. A break input forces the line low while it is held, whatever frame is in progress. A busy output reports that a frame is still on the line, which lets a host tell when the transmitter has fully drained.

Top module: `serial_tx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is low, `serial_o` is 1, `busy_o` is 0 and `in_ready_o` is 1.
- R2: A frame begins with one start bit at 0 lasting 16 strobes, followed by the data bits with bit 0 first, each lasting 16 strobes.
- R3: `line_ctrl_i[1:0]` sets the data length: 00 for 5 bits, 01 for 6, 10 for 7, 11 for 8. Word bits above the selected length are not sent.
- R4: With `line_ctrl_i[3]`=1 and `line_ctrl_i[5]`=0, one parity bit follows the last data bit: `line_ctrl_i[4]`=1 makes the count of ones over data plus parity even, `line_ctrl_i[4]`=0 makes it odd.
- R5: With `line_ctrl_i[3]`=1 and `line_ctrl_i[5]`=1, the parity bit is fixed: 0 when `line_ctrl_i[4]`=1 and 1 when `line_ctrl_i[4]`=0.
- R6: With `line_ctrl_i[3]`=0 no parity bit is sent, so a frame of n data bits and one stop bit lasts 16*(n+2) strobes.
- R7: Stop bits are 1. With `line_ctrl_i[2]`=0 the stop phase lasts 16 strobes; with `line_ctrl_i[2]`=1 it lasts 24 strobes for 5-bit words and 32 strobes for 6, 7 and 8-bit words.
- R8: While a frame is in progress, `in_ready_o` is high only during the final strobe of the stop phase, so each word is taken exactly once, and a word offered then starts its start bit with no idle gap.
- R9: While `break_i` is 1 the line is 0 from the next cycle on; frame timing keeps running, and the line follows the frame again in the cycle after `break_i` returns to 0.
- R10: `busy_o` rises the cycle after a word is accepted from idle and falls on the final strobe of the stop phase when no further word is accepted.
- R11: The line-control value is captured when a word is accepted; changes to `line_ctrl_i` during that frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Enable strobe at 16 times the bit rate |
| line_ctrl_i | input | 6 | Frame format: [1:0] length, [2] long stop, [3] parity enable, [4] even/fixed select, [5] fixed parity |
| in_valid_i | input | 1 | A data word is offered |
| in_data_i | input | 8 | Data word |
| in_ready_o | output | 1 | The offered word is taken in this cycle when valid is high |
| break_i | input | 1 | Hold the line low |
| serial_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is on the line |

## Verification
A corrupted phase or bit counter shows at the line within one bit period: a data bit sampled at its centre comes out wrong, or a frame runs a multiple of 16 strobes too long or short, which the bench measures exactly as the strobe distance between consecutive start edges of back-to-back frames. A wrong parity or stop setting changes one sampled bit or the frame length in the same frame. Handshake faults show at once as a ready pulse while busy away from the final stop strobe, or as a missing or doubled frame, and a break fault shows one cycle after the break input changes.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int unsigned WORD_W   = 8;
    localparam int unsigned MIN_BITS = 5;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } tx_phase_e;

    typedef struct packed {
        logic       fixed_par;
        logic       even_sel;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len_code;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len_code);
        return 4'(MIN_BITS) + {2'b00, len_code};
    endfunction

    function automatic logic [WORD_W-1:0] word_mask(input logic [1:0] len_code);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < int'(WORD_W); i++) begin
            m[i] = (i < int'(data_bits(len_code)));
        end
        return m;
    endfunction

    function automatic logic parity_of(input logic fixed_par, input logic even_sel,
                                       input logic [1:0] len_code,
                                       input logic [WORD_W-1:0] word);
        logic ones_odd;
        ones_odd = ^(word & word_mask(len_code));
        if (fixed_par) begin
            return ~even_sel;
        end
        return even_sel ? ones_odd : ~ones_odd;
    endfunction

    function automatic int unsigned stop_ticks(input logic long_stop,
                                               input logic [1:0] len_code,
                                               input int unsigned os);
        if (!long_stop) begin
            return os;
        end
        if (len_code == 2'b00) begin
            return os + os / 2;
        end
        return 2 * os;
    endfunction

endpackage

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic [CW-1:0] last_i,
    output logic          seg_end_o
);
    logic [CW-1:0] cnt_q;

    assign seg_end_o = tick_i && (cnt_q == last_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q <= '0;
        end else if (seg_end_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import serial_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned CW         = 5
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          valid_i,
    input  logic          seg_end_i,
    input  logic [1:0]    len_code_i,
    input  logic          long_stop_i,
    input  logic          par_en_i,
    output tx_phase_e     phase_o,
    output logic          accept_o,
    output logic          ready_o,
    output logic          shift_o,
    output logic [CW-1:0] last_o
);
    tx_phase_e  phase_q;
    logic [2:0] bit_idx_q;
    logic       last_data;

    assign ready_o   = (phase_q == PH_IDLE) || ((phase_q == PH_STOP) && seg_end_i);
    assign accept_o  = valid_i && ready_o;
    assign shift_o   = (phase_q == PH_DATA) && seg_end_i;
    assign last_data = ({1'b0, bit_idx_q} == (data_bits(len_code_i) - 4'd1));
    assign phase_o   = phase_q;

    always_comb begin
        if (phase_q == PH_STOP) begin
            last_o = CW'(stop_ticks(long_stop_i, len_code_i, OVERSAMPLE) - 1);
        end else begin
            last_o = CW'(OVERSAMPLE - 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q   <= PH_IDLE;
            bit_idx_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept_o) begin
                        phase_q <= PH_START;
                    end
                end
                PH_START: begin
                    if (seg_end_i) begin
                        phase_q   <= PH_DATA;
                        bit_idx_q <= '0;
                    end
                end
                PH_DATA: begin
                    if (seg_end_i) begin
                        if (last_data) begin
                            phase_q <= par_en_i ? PH_PARITY : PH_STOP;
                        end else begin
                            bit_idx_q <= bit_idx_q + 3'd1;
                        end
                    end
                end
                PH_PARITY: begin
                    if (seg_end_i) begin
                        phase_q <= PH_STOP;
                    end
                end
                PH_STOP: begin
                    if (seg_end_i) begin
                        phase_q <= accept_o ? PH_START : PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_word_shifter.sv
module tx_word_shifter
    import serial_tx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              fixed_par_i,
    input  logic              even_sel_i,
    input  logic [1:0]        len_code_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              par_o
);
    logic [WORD_W-1:0] sh_q;
    logic              par_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= word_i;
            par_q <= parity_of(fixed_par_i, even_sel_i, len_code_i, word_i);
        end else if (shift_i) begin
            sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
        end
    end

    assign bit_o = sh_q[0];
    assign par_o = par_q;
endmodule

// File: rtl/tx_line_drive.sv
module tx_line_drive
    import serial_tx_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  tx_phase_e phase_i,
    input  logic      data_bit_i,
    input  logic      par_bit_i,
    input  logic      break_i,
    output logic      line_o
);
    logic level;
    logic line_q;

    always_comb begin
        case (phase_i)
            PH_START:  level = 1'b0;
            PH_DATA:   level = data_bit_i;
            PH_PARITY: level = par_bit_i;
            default:   level = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            line_q <= 1'b1;
        end else begin
            line_q <= break_i ? 1'b0 : level;
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
    import serial_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic [5:0] line_ctrl_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    output logic       in_ready_o,
    input  logic       break_i,
    output logic       serial_o,
    output logic       busy_o
);
    localparam int unsigned CW = $clog2(2 * OVERSAMPLE);

    frame_cfg_t    cfg_q;
    frame_cfg_t    cfg_in;
    tx_phase_e     phase;
    logic          accept;
    logic          seg_end;
    logic          shift;
    logic [CW-1:0] seg_last;
    logic          data_bit;
    logic          par_bit;

    assign cfg_in = frame_cfg_t'(line_ctrl_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_in;
        end
    end

    tx_tick_timer #(.CW(CW)) i_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .clear_i   (phase == PH_IDLE),
        .last_i    (seg_last),
        .seg_end_o (seg_end)
    );

    tx_frame_seq #(.OVERSAMPLE(OVERSAMPLE), .CW(CW)) i_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .valid_i     (in_valid_i),
        .seg_end_i   (seg_end),
        .len_code_i  (cfg_q.len_code),
        .long_stop_i (cfg_q.long_stop),
        .par_en_i    (cfg_q.par_en),
        .phase_o     (phase),
        .accept_o    (accept),
        .ready_o     (in_ready_o),
        .shift_o     (shift),
        .last_o      (seg_last)
    );

    tx_word_shifter i_shift (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .load_i      (accept),
        .word_i      (in_data_i),
        .fixed_par_i (cfg_in.fixed_par),
        .even_sel_i  (cfg_in.even_sel),
        .len_code_i  (cfg_in.len_code),
        .shift_i     (shift),
        .bit_o       (data_bit),
        .par_o       (par_bit)
    );

    tx_line_drive i_line (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .phase_i    (phase),
        .data_bit_i (data_bit),
        .par_bit_i  (par_bit),
        .break_i    (break_i),
        .line_o     (serial_o)
    );

    assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
    input logic clk_i,
    input logic rst_i,
    input logic tick_i,
    input logic in_valid_i,
    input logic in_ready_o,
    input logic break_i,
    input logic serial_o,
    input logic busy_o
);
    // R1: idle line with no break is high one cycle later
    p_idle_high_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !break_i) |=> serial_o);

    // R2: a frame started from idle drives the start bit next
    p_start_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(busy_o) && !break_i) |=> !serial_o);

    // R7: the final stop strobe leaves the line high
    p_stop_high_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(busy_o) && !break_i) |=> serial_o);

    // R8: while busy, ready only appears on a strobe
    p_ready_tick_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && in_ready_o) |-> tick_i);

    // R9: break pulls the line low in the next cycle
    p_break_low_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        break_i |=> !serial_o);

    // R10: an accepted word leaves the block busy
    p_accept_busy_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_ready_o) |=> busy_o);
endmodule

bind serial_tx_top serial_tx_checker i_serial_tx_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .break_i    (break_i),
    .serial_o   (serial_o),
    .busy_o     (busy_o)
);

// File: tb/test_serial_tx_top.sv
`timescale 1ns/1ps
module test_serial_tx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic [5:0] line_ctrl = 6'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready;
    logic       brk = 1'b0;
    logic       serial;
    logic       busy;

    int tcount = 0;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    serial_tx_top i_serial_tx_top (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .line_ctrl_i (line_ctrl),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .break_i     (brk),
        .serial_o    (serial),
        .busy_o      (busy)
    );

    always @(negedge clk) begin
        if (rst) begin
            tdiv <= 2'd0;
            tick <= 1'b0;
        end else begin
            tdiv <= tdiv + 2'd1;
            tick <= (tdiv == 2'd3);
        end
    end

    always @(posedge clk) begin
        if (tick) tcount <= tcount + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] mk_cfg(input int nb, input bit long_stop, input bit pen,
                                          input bit even, input bit fixed);
        logic [1:0] lc;
        lc = 2'(nb - 5);
        return {fixed, even, pen, long_stop, lc};
    endfunction

    function automatic int cfg_bits(input logic [5:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic [7:0] mask_of(input int nb);
        return 8'((1 << nb) - 1);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [5:0] c);
        logic [7:0] m;
        m = d & mask_of(cfg_bits(c));
        if (c[5]) return ~c[4];
        return c[4] ? ^m : ~^m;
    endfunction

    task automatic wait_tick(input int target);
        while (tcount < target) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [5:0] c);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        line_ctrl = c;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic rx_frame(input int nb, input bit hp, output logic [7:0] d, output logic pb,
                            output logic start_v, output logic stop_v, output int t0);
        int pos;
        d  = 8'd0;
        pb = 1'b0;
        do @(negedge clk); while (serial !== 1'b0);
        t0 = tcount;
        wait_tick(t0 + 8);
        start_v = serial;
        for (int k = 0; k < nb; k++) begin
            wait_tick(t0 + 8 + 16 * (k + 1));
            d[k] = serial;
        end
        pos = nb + 1;
        if (hp) begin
            wait_tick(t0 + 8 + 16 * pos);
            pb = serial;
            pos++;
        end
        wait_tick(t0 + 8 + 16 * pos);
        stop_v = serial;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "reset line", int'(serial), 1);
        chk("R1", "reset busy", int'(busy), 0);
        #1;
        chk("R1", "reset ready", int'(in_ready), 1);
    endtask

    // One frame from idle: start, data order, length masking, parity, stop, busy
    task automatic t_frame(input logic [7:0] w, input logic [5:0] c, input string req);
        logic [7:0] d;
        logic pb, sv, stv;
        int t0, nb;
        nb = cfg_bits(c);
        fork
            send(w, c);
            rx_frame(nb, c[3], d, pb, sv, stv, t0);
        join
        chk("R2", "start bit", int'(sv), 0);
        chk(req, "data word", int'(d), int'(w & mask_of(nb)));
        if (c[3]) chk(req, "parity bit", int'(pb), int'(exp_par(w, c)));
        chk("R7", "stop bit level", int'(stv), 1);
        wait_idle();
        chk("R1", "line after frame", int'(serial), 1);
        chk("R10", "busy after frame", int'(busy), 0);
    endtask

    // Three words back to back; frame length between consecutive start edges
    task automatic t_stream(input logic [5:0] c, input int exp_ticks, input string req);
        logic [7:0] words [3];
        logic [7:0] d;
        logic pb, sv, stv;
        int ts [3];
        int nb;
        words[0] = 8'hA5; words[1] = 8'h3C; words[2] = 8'h96;
        nb = cfg_bits(c);
        fork
            begin
                for (int i = 0; i < 3; i++) send(words[i], c);
            end
            begin
                for (int i = 0; i < 3; i++) begin
                    rx_frame(nb, c[3], d, pb, sv, stv, ts[i]);
                    chk("R8", "streamed word", int'(d), int'(words[i] & mask_of(nb)));
                end
            end
        join
        chk(req, "frame strobes", ts[2] - ts[1], exp_ticks);
        wait_idle();
        chk("R8", "no extra frame", int'(busy), 0);
    endtask

    // R8: ready seen while busy only on the final stop strobe
    task automatic t_ready_once();
        int seen;
        seen = 0;
        send(8'h5A, mk_cfg(7, 0, 1, 0, 0));
        forever begin
            @(negedge clk);
            #1;
            if (!busy) break;
            if (in_ready) seen++;
        end
        chk("R8", "ready pulses in frame", seen, 1);
        wait_idle();
    endtask

    task automatic t_break_idle();
        int bad;
        bad = 0;
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk("R9", "break from idle", int'(serial), 0);
        repeat (20) begin
            @(negedge clk);
            if (serial !== 1'b0) bad++;
        end
        chk("R9", "break held low", bad, 0);
        chk("R9", "break starts no frame", int'(busy), 0);
        brk = 1'b0;
        @(negedge clk);
        chk("R9", "release to idle", int'(serial), 1);
    endtask

    // R9/R10: break in mid-frame, timing keeps running
    task automatic t_break_frame();
        int t0, bad;
        bad = 0;
        send(8'hFF, mk_cfg(8, 0, 0, 0, 0));
        t0 = tcount;
        @(negedge clk);
        chk("R10", "busy after accept", int'(busy), 1);
        wait_tick(t0 + 40);
        brk = 1'b1;
        @(negedge clk);
        chk("R9", "break over data 1", int'(serial), 0);
        while (tcount < t0 + 60) begin
            @(negedge clk);
            if (serial !== 1'b0) bad++;
        end
        chk("R9", "break held in frame", bad, 0);
        brk = 1'b0;
        wait_tick(t0 + 72);
        chk("R9", "frame resumes", int'(serial), 1);
        wait_tick(t0 + 159);
        chk("R10", "busy before last strobe", int'(busy), 1);
        wait_tick(t0 + 160);
        chk("R10", "busy falls on last strobe", int'(busy), 0);
        wait_idle();
    endtask

    // R11: line control altered after acceptance
    task automatic t_cfg_capture();
        logic [7:0] d;
        logic pb, sv, stv;
        int t0;
        logic [5:0] c;
        c = mk_cfg(8, 0, 1, 1, 0);
        fork
            begin
                send(8'hB7, c);
                line_ctrl = mk_cfg(5, 1, 1, 0, 1);
            end
            rx_frame(8, 1'b1, d, pb, sv, stv, t0);
        join
        chk("R11", "data kept", int'(d), 8'hB7);
        chk("R11", "parity kept", int'(pb), int'(exp_par(8'hB7, c)));
        chk("R11", "stop kept", int'(stv), 1);
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(8'h4D, mk_cfg(8, 0, 0, 0, 0), "R2");
        t_frame(8'hE5, mk_cfg(5, 0, 0, 0, 0), "R3");
        t_frame(8'hFA, mk_cfg(6, 0, 0, 0, 0), "R3");
        t_frame(8'hC9, mk_cfg(7, 0, 1, 1, 0), "R4");
        t_frame(8'h13, mk_cfg(8, 0, 1, 1, 0), "R4");
        t_frame(8'h13, mk_cfg(8, 0, 1, 0, 0), "R4");
        t_frame(8'h21, mk_cfg(6, 0, 1, 1, 1), "R5");
        t_frame(8'h21, mk_cfg(6, 0, 1, 0, 1), "R5");
        t_stream(mk_cfg(8, 0, 0, 0, 0), 160, "R6");
        t_stream(mk_cfg(5, 1, 0, 0, 0), 120, "R7");
        t_stream(mk_cfg(8, 1, 1, 1, 0), 192, "R7");
        t_stream(mk_cfg(6, 0, 1, 0, 0), 144, "R8");
        t_ready_once();
        t_break_idle();
        t_break_frame();
        t_cfg_capture();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule